// File: doc/BRIEF.md
# Programmable COM Window Select Decoder

This block produces the chip select and register index for a UART register set that sits on a host I/O bus. Firmware picks the UART's place in host I/O space by writing a register, so no jumpers or external glue logic are needed. The host address bits above the register index are compared with the base of one of four standard serial port windows. The select is asserted only while a host read or write strobe is active, the window matches, the access is not a DMA mailbox cycle, and decoding has been enabled.

Decoding is controlled by a three-state machine. After reset the machine is in `CW_BLANK`, and any enable write is ignored there. The transition `dec_write` to `CW_PRIMED` is taken on the first write of the window register. The transition `enable_set` to `CW_ACTIVE` is taken when a mode-register write has the enable bit at 1. The transition `enable_clear` back to `CW_PRIMED` is taken when a mode-register write has the enable bit at 0. A force bit in the window register copies the select onto a separate output for use by external logic. The window and the state are registered, and everything else is combinational.

Top module: `com_window_decoder`

## Requirements
- R1: After reset, `uart_sel`, `ext_sel` and `uart_reg_idx` are 0 for every host access.
- R2: A mode-register write (`cfg_target`=1) is ignored until the window register (`cfg_target`=0) has been written at least once, so later host accesses are not selected.
- R3: A window write followed by a mode write with `cfg_wdata[0]`=1 enables decoding from the cycle after that mode write. In the cycle of the mode write itself, decoding is still off.
- R4: The window field `cfg_wdata[1:0]` selects the base address: 0 gives 3F8h, 1 gives 2F8h, 2 gives 3E8h and 3 gives 2E8h. An access is selected exactly when `host_addr[9:3]` equals `base[9:3]`.
- R5: The select requires `host_rd` or `host_wr` to be high, and it falls in the same cycle that both strobes go low.
- R6: While `mbox_acc` is high, `uart_sel` is 0.
- R7: `uart_reg_idx` equals `host_addr[2:0]` while `uart_sel` is 1, and it is 0 otherwise.
- R8: With the force bit `cfg_wdata[2]` set in the last window write, `ext_sel` equals `uart_sel`. With the bit clear, `ext_sel` is 0.
- R9: A mode write with `cfg_wdata[0]`=0 disables decoding from the next cycle. A later mode write with the bit at 1 re-enables decoding without a new window write.
- R10: A window write while decoding is enabled keeps decoding enabled. The old window applies in the cycle of the write, and the new window applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 10 | Host I/O address |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| mbox_acc | input | 1 | Current host cycle is a DMA mailbox access |
| cfg_we | input | 1 | Local register write strobe |
| cfg_target | input | 1 | 0 = window register, 1 = mode register |
| cfg_wdata | input | 8 | Local write data |
| uart_sel | output | 1 | UART register-set select |
| uart_reg_idx | output | 3 | UART register index |
| ext_sel | output | 1 | Select copied to the external pin when forced |

## Verification
A local register write and a host access can fall in the same cycle. Two cases are provoked this way. In the first, a host read of 3F8h is driven while the mode write that sets the enable is being made. In the second, a host read of the old window is driven while the window register is rewritten with decoding enabled. In both cases the select is judged in that cycle, where the previous state or window must still govern, and again one cycle later, where the new setting must govern.

// File: rtl/comwin_pkg.sv
package comwin_pkg;

    localparam int unsigned HOST_AW = 10;
    localparam int unsigned NUM_WIN = 4;
    localparam int unsigned WIN_W   = $clog2(NUM_WIN);

    typedef enum logic [1:0] {
        CW_BLANK  = 2'd0,
        CW_PRIMED = 2'd1,
        CW_ACTIVE = 2'd2
    } cw_state_t;

    function automatic logic [HOST_AW-1:0] win_base(input logic [WIN_W-1:0] w);
        logic [HOST_AW-1:0] b;
        case (w)
            2'd0:    b = 10'h3F8;
            2'd1:    b = 10'h2F8;
            2'd2:    b = 10'h3E8;
            default: b = 10'h2E8;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/comwin_ctrl.sv
module comwin_ctrl
    import comwin_pkg::*;
#(
    parameter int unsigned CFG_DW    = 8,
    parameter int unsigned WIN_LSB   = 0,
    parameter int unsigned FORCE_BIT = 2,
    parameter int unsigned EN_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_target,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              live,
    output logic [WIN_W-1:0]  win_q,
    output logic              force_q
);

    cw_state_t st_q, st_d;
    logic      dec_wr, mode_wr, en_val;

    assign dec_wr  = cfg_we && !cfg_target;
    assign mode_wr = cfg_we &&  cfg_target;
    assign en_val  = cfg_wdata[EN_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CW_BLANK;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CW_BLANK:  if (dec_wr)             st_d = CW_PRIMED;
            CW_PRIMED: if (mode_wr && en_val)  st_d = CW_ACTIVE;
            CW_ACTIVE: if (mode_wr && !en_val) st_d = CW_PRIMED;
            default:                           st_d = CW_BLANK;
        endcase
    end

    always_comb begin
        live = 1'b0;
        unique case (st_q)
            CW_ACTIVE: live = 1'b1;
            default:   live = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            force_q <= 1'b0;
        end else if (dec_wr) begin
            win_q   <= cfg_wdata[WIN_LSB +: WIN_W];
            force_q <= cfg_wdata[FORCE_BIT];
        end
    end

    // R2: an enable write while blank leaves decoding off
    a_r2_early_enable_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CW_BLANK && mode_wr) |=> !live);

    // R3: decoding only turns on after a mode write carrying the enable bit
    a_r3_enable_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live) |-> $past(mode_wr && en_val));

    // R9: a clearing mode write turns decoding off next cycle
    a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !en_val) |=> !live);

endmodule

// File: rtl/comwin_match.sv
module comwin_match
    import comwin_pkg::*;
#(
    parameter int unsigned IDX_W = 3
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic [WIN_W-1:0]   win,
    output logic               hit
);

    localparam int unsigned CMP_W = HOST_AW - IDX_W;

    logic [NUM_WIN-1:0] win_hit;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [HOST_AW-1:0] BASE = win_base(WIN_W'(g));
        assign win_hit[g] = (addr[HOST_AW-1:IDX_W] == BASE[HOST_AW-1:IDX_W]);
    end

    assign hit = win_hit[win];

    // R4: the windows are disjoint, so at most one can match
    a_r4_disjoint: assert final ($onehot0(win_hit) || $isunknown(addr));

    logic [CMP_W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: rtl/com_window_decoder.sv
module com_window_decoder
    import comwin_pkg::*;
#(
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned CFG_DW    = 8,
    parameter int unsigned WIN_LSB   = 0,
    parameter int unsigned FORCE_BIT = 2,
    parameter int unsigned EN_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              mbox_acc,
    input  logic              cfg_we,
    input  logic              cfg_target,
    input  logic [7:0]        cfg_wdata,
    output logic              uart_sel,
    output logic [2:0]        uart_reg_idx,
    output logic              ext_sel
);

    logic             live, force_q, hit, strobe;
    logic [WIN_W-1:0] win_q;

    comwin_ctrl #(
        .CFG_DW(CFG_DW), .WIN_LSB(WIN_LSB), .FORCE_BIT(FORCE_BIT), .EN_BIT(EN_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_target(cfg_target),
        .cfg_wdata(cfg_wdata), .live(live), .win_q(win_q), .force_q(force_q)
    );

    comwin_match #(.IDX_W(IDX_W)) u_match (
        .addr(host_addr), .win(win_q), .hit(hit)
    );

    assign strobe       = host_rd || host_wr;
    assign uart_sel     = live && hit && strobe && !mbox_acc;
    assign uart_reg_idx = uart_sel ? host_addr[IDX_W-1:0] : '0;
    assign ext_sel      = uart_sel && force_q;

    // R5: no select without a strobe
    a_r5_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        uart_sel |-> (host_rd || host_wr));

    // R6: mailbox cycles are never selected
    a_r6_mailbox_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_acc |-> !uart_sel);

    // R7: index is zero while not selected
    a_r7_idx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_sel |-> (uart_reg_idx == '0));

    // R8: the external copy never leads the internal select
    a_r8_ext_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> uart_sel);

endmodule

// File: tb/com_window_decoder_tb_top.sv
module com_window_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] host_addr;
    logic       host_rd, host_wr, mbox_acc;
    logic       cfg_we, cfg_target;
    logic [7:0] cfg_wdata;
    logic       uart_sel, ext_sel;
    logic [2:0] uart_reg_idx;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    com_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .mbox_acc(mbox_acc), .cfg_we(cfg_we),
        .cfg_target(cfg_target), .cfg_wdata(cfg_wdata), .uart_sel(uart_sel),
        .uart_reg_idx(uart_reg_idx), .ext_sel(ext_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (addr=%h t=%0t)", req, act, exp, host_addr, $time);
        end
    endtask

    task automatic cfg_write(input logic tgt, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_target = tgt; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic host(input logic [9:0] a, input logic rd, input logic wr, input logic mb);
        host_addr = a; host_rd = rd; host_wr = wr; mbox_acc = mb;
        #1;
    endtask

    function automatic logic [9:0] exp_base(input int w);
        return 10'(32'h3F8 - 32'h100 * (w % 2) - 32'h10 * (w / 2));
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; host_addr = '0; host_rd = 0; host_wr = 0; mbox_acc = 0;
        cfg_we = 0; cfg_target = 0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        host(10'h3F8, 1, 0, 0);
        chk("R1 sel", uart_sel, 0);
        chk("R1 idx", uart_reg_idx, 0);
        chk("R1 ext", ext_sel, 0);

        // R2: enable before window write is ignored
        cfg_write(1'b1, 8'h01);
        host(10'h3F8, 1, 0, 0);
        chk("R2 sel", uart_sel, 0);
        cfg_write(1'b0, 8'h00);
        host(10'h3FA, 0, 1, 0);
        chk("R2 still off after window write", uart_sel, 0);

        // R3: enable write collides with a host access
        @(negedge clk);
        cfg_we = 1; cfg_target = 1; cfg_wdata = 8'h01;
        host(10'h3F9, 1, 0, 0);
        chk("R3 same cycle", uart_sel, 0);
        @(negedge clk);
        cfg_we = 0;
        #1;
        chk("R3 next cycle", uart_sel, 1);
        chk("R7 idx", uart_reg_idx, 1);

        // R4 R5 R7 R8: sweep windows, addresses and strobes
        for (int w = 0; w < 4; w++) begin
            cfg_write(1'b0, 8'((w % 2) << 2) | 8'(w));
            for (int a = 0; a < 1024; a++) begin
                for (int s = 0; s < 4; s++) begin
                    @(negedge clk);
                    host(10'(a), s[0], s[1], 0);
                    begin
                        int m, e;
                        m = (10'(a) >> 3) == (exp_base(w) >> 3) ? 1 : 0;
                        e = (m == 1 && s != 0) ? 1 : 0;
                        chk(s == 0 ? "R5 sel" : "R4 sel", uart_sel, e);
                        chk("R7 idx", uart_reg_idx, e ? (a % 8) : 0);
                        chk("R8 ext", ext_sel, (w % 2 == 1) ? e : 0);
                    end
                end
            end
        end

        // R6: mailbox cycles excluded (window 3 still set)
        @(negedge clk);
        host(10'h2EC, 1, 0, 1);
        chk("R6 sel", uart_sel, 0);
        chk("R6 ext", ext_sel, 0);
        host(10'h2EC, 1, 0, 0);
        chk("R6 control", uart_sel, 1);

        // R5: strobe drop deasserts in the same cycle
        host(10'h2EC, 0, 0, 0);
        chk("R5 drop", uart_sel, 0);

        // R9: disable and re-enable
        cfg_write(1'b1, 8'h00);
        host(10'h2E8, 0, 1, 0);
        chk("R9 disabled", uart_sel, 0);
        cfg_write(1'b1, 8'h01);
        host(10'h2E8, 0, 1, 0);
        chk("R9 re-enabled", uart_sel, 1);

        // R10: window rewrite while active, collided with a host access
        @(negedge clk);
        cfg_we = 1; cfg_target = 0; cfg_wdata = 8'h00;
        host(10'h2E8, 1, 0, 0);
        chk("R10 old window same cycle", uart_sel, 1);
        @(negedge clk);
        cfg_we = 0;
        #1;
        chk("R10 old window next cycle", uart_sel, 0);
        host(10'h3FF, 1, 0, 0);
        chk("R10 new window", uart_sel, 1);
        chk("R10 idx", uart_reg_idx, 7);
        chk("R8 force cleared", ext_sel, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule